// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the setup word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 2-bit test selector. Two paths can write it, and both target one shared set of registers. The parallel path takes the divide values from pins under an active-low load strobe. The serial path takes them from a three-wire port made of a serial clock, serial data and a serial load strobe.

All strobes, the serial clock and the data pins pass through two-flop synchronisers into one system clock domain. Edges are found from the synchronised copies. A test output shows one of four sources, chosen by the test selector. It is held low in parallel mode and while master reset is asserted. Master reset never alters the stored setup.

Top module: `synth_cfg_loader`

## Requirements
- R1: After the synchronous power-up reset (`rst_n` low), `m_val` holds DEF_M (28), `n_sel` holds DEF_N (1) and `t_bits` holds 00.
- R2: While the synchronised `par_ld_n` is low, `m_val` and `n_sel` follow `par_m` and `par_n`, three system clocks behind the pins. `t_bits` is left as it was.
- R3: Once `par_ld_n` returns high, the last pin values stay in force even when the pins change, until a serial load happens.
- R4: A serial frame is 14 bits, sent most significant first on rising `ser_clk` edges while `par_ld_n` is high. The order is T1, T0, one ignored null bit, N1, N0, then M8 down to M0. A rising `ser_ld` copies the shift register into `t_bits`, `n_sel` and `m_val`.
- R5: When `par_ld_n` is high and `ser_ld` is low, changes on the pins, on `ser_dat` or on `ser_clk` leave `m_val`, `n_sel` and `t_bits` unchanged. A falling `ser_ld` also changes nothing.
- R6: While `ser_ld` is held high, every rising `ser_clk` edge shifts in one bit, and the updated shift register appears at once in the three registers.
- R7: When a rising `ser_clk` and a rising `ser_ld` land in the same synchronised cycle, the registers receive the shift register including the bit shifted in on that edge.
- R8: With the block in serial mode and master reset low, `test_o` shows a source chosen by `t_bits`: 00 gives low, 01 gives the synchronised `ser_dat`, 10 gives `mdiv_mon`, and 11 gives `fout_mon`.
- R9: `test_o` is low whenever the synchronised `par_ld_n` is low.
- R10: While `mreset` is high, `test_o` is low and `m_val`, `n_sel` and `t_bits` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| mreset | input | 1 | Master reset; forces `test_o` low and does not touch the setup |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_ld | input | 1 | Serial load strobe (asynchronous) |
| par_ld_n | input | 1 | Parallel load strobe, active low (asynchronous) |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| mdiv_mon | input | 1 | Feedback divider output, routed to `test_o` |
| fout_mon | input | 1 | Output clock, routed to `test_o` |
| m_val | output | 9 | Active feedback divide value |
| n_sel | output | 2 | Active output divide select |
| t_bits | output | 2 | Active test selector |
| test_o | output | 1 | Test output |

## Verification
Two events can arrive in the same synchronised cycle: a serial shift and the rising edge of the load strobe. In that case the load must capture the bit shifted in on that edge. The bench shifts 13 bits of a frame, then raises the serial clock for the last bit and the load strobe on the same clock edge. It then compares all three registers against the complete 14-bit frame. If the design loaded the register contents from before the shift, the result would be the frame shifted by one bit, so the two outcomes are easy to tell apart.

// File: rtl/cfg_loader_pkg.sv
// Shared definitions for the synthesizer configuration loader.
// Assumes the test selector is two bits wide.
package cfg_loader_pkg;
    typedef enum logic [1:0] {
        TSEL_LOW  = 2'b00,
        TSEL_SDAT = 2'b01,
        TSEL_MDIV = 2'b10,
        TSEL_FOUT = 2'b11
    } tsel_e;
endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous bits.
// Assumes each bit is a level that is held for several system clocks.
module cfg_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop rank of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[g] <= RST_V;
                else if (g == 0)
                    stg[g] <= d_i;
                else
                    stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_regs.sv
// Holds the active divide and test values plus the serial shift register.
// Parallel mode has priority. A serial load fires on a rising serial load
// strobe, or on a serial clock rise while that strobe is high, and always
// uses the shift value that includes the current cycle's shift.
// Assumes all inputs come already synchronised to clk.
module cfg_regs #(
    parameter int             M_W   = 9,
    parameter int             N_W   = 2,
    parameter int             T_W   = 2,
    parameter logic [M_W-1:0] DEF_M = 9'd28,
    parameter logic [N_W-1:0] DEF_N = 2'd1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdat,
    input  logic           sld,
    input  logic           pld_n,
    input  logic [M_W-1:0] pm,
    input  logic [N_W-1:0] pn,
    output logic [M_W-1:0] m_q,
    output logic [N_W-1:0] n_q,
    output logic [T_W-1:0] t_q
);
    localparam int FR_W = T_W + 1 + N_W + M_W;

    logic [FR_W-1:0] sh_q, sh_nx;
    logic            sclk_d, sld_d;
    logic            sclk_rise, sld_rise, shift_en, load_ser;

    // Purpose: find edges, select the next shift value and the load condition.
    always_comb begin
        sclk_rise = sclk & ~sclk_d;
        sld_rise  = sld & ~sld_d;
        shift_en  = pld_n & sclk_rise;
        sh_nx     = shift_en ? {sh_q[FR_W-2:0], sdat} : sh_q;
        load_ser  = pld_n & (sld_rise | (sld & sclk_rise));
    end

    // Purpose: update edge history, shift register and active setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sld_d  <= 1'b0;
            sh_q   <= '0;
            m_q    <= DEF_M;
            n_q    <= DEF_N;
            t_q    <= '0;
        end else begin
            sclk_d <= sclk;
            sld_d  <= sld;
            sh_q   <= sh_nx;
            if (!pld_n) begin
                m_q <= pm;
                n_q <= pn;
            end else if (load_ser) begin
                m_q <= sh_nx[M_W-1:0];
                n_q <= sh_nx[M_W+N_W-1:M_W];
                t_q <= sh_nx[FR_W-1 -: T_W];
            end
        end
    end
endmodule

// File: rtl/cfg_test_mux.sv
// Chooses the test output source from the test selector.
// Assumes the monitor clocks go through without being registered.
module cfg_test_mux
    import cfg_loader_pkg::*;
(
    input  logic [1:0] t_sel,
    input  logic       mreset,
    input  logic       pld_n,
    input  logic       sdat,
    input  logic       mdiv,
    input  logic       fout,
    output logic       test_o
);
    // Purpose: gate the output, then select its source.
    always_comb begin
        test_o = 1'b0;
        if (!mreset && pld_n) begin
            case (tsel_e'(t_sel))
                TSEL_LOW:  test_o = 1'b0;
                TSEL_SDAT: test_o = sdat;
                TSEL_MDIV: test_o = mdiv;
                TSEL_FOUT: test_o = fout;
                default:   test_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/synth_cfg_loader.sv
// Top of the synthesizer configuration loader: input synchroniser,
// register bank and test output mux.
// Assumes the strobes and the serial clock are slow next to clk.
module synth_cfg_loader #(
    parameter int             M_W    = 9,
    parameter int             N_W    = 2,
    parameter int             T_W    = 2,
    parameter int             STAGES = 2,
    parameter logic [M_W-1:0] DEF_M  = 9'd28,
    parameter logic [N_W-1:0] DEF_N  = 2'd1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mreset,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           par_ld_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           mdiv_mon,
    input  logic           fout_mon,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_sel,
    output logic [T_W-1:0] t_bits,
    output logic           test_o
);
    localparam int           SB_W  = N_W + M_W + 4;
    localparam logic [SB_W-1:0] SB_RST = SB_W'(8);

    logic [SB_W-1:0] raw_bus, sync_bus;
    logic            s_sclk, s_sdat, s_sld, s_pld_n;
    logic [M_W-1:0]  s_pm;
    logic [N_W-1:0]  s_pn;

    assign raw_bus = {par_n, par_m, par_ld_n, ser_ld, ser_dat, ser_clk};
    assign {s_pn, s_pm, s_pld_n, s_sld, s_sdat, s_sclk} = sync_bus;

    cfg_sync #(.W(SB_W), .STAGES(STAGES), .RST_V(SB_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_bus), .q_o(sync_bus)
    );

    cfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .DEF_M(DEF_M), .DEF_N(DEF_N)) u_regs (
        .clk(clk), .rst_n(rst_n), .sclk(s_sclk), .sdat(s_sdat), .sld(s_sld),
        .pld_n(s_pld_n), .pm(s_pm), .pn(s_pn),
        .m_q(m_val), .n_q(n_sel), .t_q(t_bits)
    );

    cfg_test_mux u_tmux (
        .t_sel(t_bits[1:0]), .mreset(mreset), .pld_n(s_pld_n), .sdat(s_sdat),
        .mdiv(mdiv_mon), .fout(fout_mon), .test_o(test_o)
    );
endmodule

// File: rtl/cfg_loader_chk.sv
// Property checker for synth_cfg_loader, bound into every instance.
// Tracks its own edge history for the synchronised strobes.
module cfg_loader_chk #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mreset,
    input logic           s_pld_n,
    input logic           s_sld,
    input logic           s_sclk,
    input logic           s_sdat,
    input logic [M_W-1:0] s_pm,
    input logic [M_W-1:0] m_val,
    input logic [N_W-1:0] n_sel,
    input logic [T_W-1:0] t_bits,
    input logic           test_o
);
    logic sclk_q, sld_q;

    // Purpose: previous synchronised levels, used to find edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sld_q  <= 1'b0;
        end else begin
            sclk_q <= s_sclk;
            sld_q  <= s_sld;
        end
    end

    // R2
    parallel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_pld_n |=> m_val == $past(s_pm));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pld_n && !(s_sld && !sld_q) && !(s_sld && s_sclk && !sclk_q))
        |=> ($stable(m_val) && $stable(n_sel) && $stable(t_bits)));

    // R6
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pld_n && s_sld && s_sclk && !sclk_q) |=> m_val[0] == $past(s_sdat));

    // R9
    par_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_pld_n |-> !test_o);

    // R10
    mr_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |-> !test_o);
endmodule

bind synth_cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .s_pld_n(s_pld_n), .s_sld(s_sld),
    .s_sclk(s_sclk), .s_sdat(s_sdat), .s_pm(s_pm), .m_val(m_val), .n_sel(n_sel),
    .t_bits(t_bits), .test_o(test_o)
);

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
    logic clk = 1'b0, rst_n = 1'b0, mreset = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld_n = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic mdiv_mon = 1'b0, fout_mon = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_sel, t_bits;
    logic test_o;

    int vecs = 0, errs = 0;
    logic [13:0] shadow = '0;
    logic [8:0]  em;
    logic [1:0]  en, et;

    // bit 14: 1 = serial frame, 0 = parallel; [13:12] T, [11] null, [10:9] N, [8:0] M
    localparam logic [14:0] VECS [6] = '{15'h04A5, 15'h4BFF, 15'h7600,
                                          15'h0155, 15'h44AA, 15'h6101};

    always #4 clk = ~clk;

    synth_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .mreset(mreset), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .par_ld_n(par_ld_n), .par_m(par_m), .par_n(par_n),
        .mdiv_mon(mdiv_mon), .fout_mon(fout_mon), .m_val(m_val), .n_sel(n_sel),
        .t_bits(t_bits), .test_o(test_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_regs(input string req);
        chk(req, {23'd0, m_val}, {23'd0, em});
        chk(req, {30'd0, n_sel}, {30'd0, en});
        chk(req, {30'd0, t_bits}, {30'd0, et});
    endtask

    task automatic sbit(input logic b);
        ser_dat = b; ser_clk = 1'b0; wt(3);
        ser_clk = 1'b1; wt(4);
        ser_clk = 1'b0;
        shadow = {shadow[12:0], b};
    endtask

    task automatic from_shadow();
        em = shadow[8:0]; en = shadow[10:9]; et = shadow[13:12];
    endtask

    task automatic send_frame(input logic [13:0] f);
        ser_ld = 1'b0;
        for (int i = 13; i >= 0; i--) sbit(f[i]);
        ser_ld = 1'b1; wt(4);
        ser_ld = 1'b0; wt(4);
        from_shadow();
    endtask

    initial begin
        #(200000 * 8);
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        wt(3); rst_n = 1'b1; wt(1);
        em = 9'd28; en = 2'd1; et = 2'd0;
        chk_regs("R1 reset defaults");

        for (int k = 0; k < 6; k++) begin
            if (VECS[k][14]) begin
                send_frame(VECS[k][13:0]);
                chk_regs("R4 serial frame");
            end else begin
                par_m = VECS[k][8:0]; par_n = VECS[k][10:9];
                par_ld_n = 1'b0; wt(4);
                em = VECS[k][8:0]; en = VECS[k][10:9];
                chk_regs("R2 parallel transparent");
                chk("R9 test low in parallel", {31'd0, test_o}, 32'd0);
                par_ld_n = 1'b1; wt(4);
                par_m = ~par_m; par_n = ~par_n; wt(4);
                chk_regs("R3 parallel latched");
            end
        end

        // R5: idle strobes, pins and serial activity have no effect
        par_m = 9'h0F0; par_n = 2'd3;
        sbit(1'b1); sbit(1'b0); sbit(1'b1); wt(4);
        chk_regs("R5 idle hold");

        // R6: transparent serial load while strobe held high
        ser_ld = 1'b1; wt(4);
        from_shadow();
        chk_regs("R6 strobe rise load");
        sbit(1'b1); from_shadow(); chk_regs("R6 transparent bit1");
        sbit(1'b0); from_shadow(); chk_regs("R6 transparent bit2");
        sbit(1'b1); from_shadow(); chk_regs("R6 transparent bit3");
        ser_ld = 1'b0; wt(4);
        chk_regs("R5 strobe fall hold");

        // R7: last shift and load strobe rise in the same cycle; frame T=01 N=2 M=0x133
        begin
            logic [13:0] f;
            f = 14'h1533;
            for (int i = 13; i >= 1; i--) sbit(f[i]);
            ser_dat = f[0]; ser_clk = 1'b0; wt(3);
            ser_clk = 1'b1; ser_ld = 1'b1; wt(4);
            ser_clk = 1'b0;
            shadow = {shadow[12:0], f[0]};
            em = 9'h133; en = 2'd2; et = 2'd1;
            chk_regs("R7 concurrent shift and load");
            ser_ld = 1'b0; wt(4);
        end

        // R8: selector 01 shows synchronised serial data
        ser_dat = 1'b1; wt(3);
        chk("R8 sel01 data high", {31'd0, test_o}, 32'd1);
        ser_dat = 1'b0; wt(3);
        chk("R8 sel01 data low", {31'd0, test_o}, 32'd0);

        // R8: selector 10 shows divider monitor
        send_frame(14'h2011);
        mdiv_mon = 1'b1; #1;
        chk("R8 sel10 mdiv high", {31'd0, test_o}, 32'd1);
        @(negedge clk); mdiv_mon = 1'b0; #1;
        chk("R8 sel10 mdiv low", {31'd0, test_o}, 32'd0);

        // R8: selector 11 shows output clock; selector 00 low
        send_frame(14'h3022);
        fout_mon = 1'b1; #1;
        chk("R8 sel11 fout high", {31'd0, test_o}, 32'd1);

        // R10: master reset forces test low and keeps setup
        @(negedge clk); mreset = 1'b1; #1;
        chk("R10 test low in mreset", {31'd0, test_o}, 32'd0);
        wt(4);
        chk_regs("R10 mreset keeps setup");
        mreset = 1'b0; #1;
        chk("R10 test back after mreset", {31'd0, test_o}, 32'd1);

        // R9: parallel mode forces test low (pins equal current setup)
        @(negedge clk); par_m = em; par_n = en; par_ld_n = 1'b0; wt(4);
        chk("R9 test low in parallel", {31'd0, test_o}, 32'd0);
        par_ld_n = 1'b1; wt(4);
        chk("R9 test restored", {31'd0, test_o}, 32'd1);

        send_frame(14'h0044);
        chk("R8 sel00 low", {31'd0, test_o}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule